// File: doc/BRIEF.md
# EEPROM parallel row-write controller

This block sits between a CPU bus and a small on-chip non-volatile byte array and decides when and how the array is written. Software steers it through one 8-bit control register, selected by `ctl_sel`. With the enable bit set and the row-mode bit clear, each data write starts a timed programming cycle for that single byte. With the row-mode bit set, data writes are not committed at once. They are captured into eight volatile lane latches, each with its own valid flag. The first captured write fixes the target row. Setting the start bit then commits only the captured lanes in one programming cycle of `PROG_CYC` clocks.

While a cycle runs, the busy flag is high. Array accesses are refused and flagged on `acc_err`, and control writes are ignored. At the end of a row cycle the hardware clears both the start bit and the row-mode bit, so every row commit has to be armed again by software. A standby bit silences the array: data accesses then do nothing, and reads return zero. The array is modelled as a register array that resets to all zeros.

Top module: `nvr_row_writer`

## Requirements
- R1: After reset the control register reads 00h, busy and acc_err are 0, bus_rdata is 00h, and every array byte reads 00h.
- R2: A control-register read returns enable at bit 0, busy at bit 1, row mode at bit 2, start at bit 3 and standby at bit 6. Bits 7, 5 and 4 always read 0, whatever was written to them.
- R3: With enable=1, row mode=0 and standby=0, a data write starts a byte programming cycle. Busy is 1 for exactly PROG_CYC cycles, starting the cycle after the write, and the addressed byte holds the new value once busy falls.
- R4: A control write that sets row mode while it is clear empties all eight lane latches. The first data write after that locks the row to address bits 7..3 and stores the byte in lane bits 2..0.
- R5: A row commit updates exactly the lanes written since row mode was set. For example, writes to 18h, 1Ah and 1Bh change only those three bytes, and 19h, 1Ch..1Fh keep their values.
- R6: A write with bits 3, 2 and 0 set and bit 6 clear starts a row cycle only if enable=1, row mode=1 and standby=0 before the write. Otherwise the start bit reads 0 and busy stays 0.
- R7: When a programming cycle ends, the start bit and the row-mode bit both read 0.
- R8: Clearing row mode before a start discards the captured lanes. A later row cycle then leaves the array unchanged.
- R9: While busy, a data read or write sets acc_err for one cycle, changes nothing and reads 00h. A control write is ignored, and the cycle in progress still completes.
- R10: In row mode, a data write to a row other than the locked one sets acc_err and is not captured. A data read in row mode sets acc_err and returns 00h.
- R11: While standby=1, data writes have no effect and start no cycle, data reads return 00h, and acc_err stays 0.
- R12: With enable=0 and row mode=0, a data write is ignored and the array is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_sel | input | 1 | 1 selects the control register, 0 selects the array |
| bus_addr | input | ADDR_W (8) | Array byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, valid the cycle after a read |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe, wins over rd_en |
| busy | output | 1 | Programming cycle in progress |
| acc_err | output | 1 | One-cycle flag for a rejected array access |

## Verification
The assertions assume that the bus strobes are single-cycle and that the inputs are stable around each rising edge. The busy-length and start-gating properties also assume that standby and a start request never reach the block in the same write. The bench drives every strobe on the falling edge, one access per cycle, and it never combines the standby bit with a start. A behavioural model checks every clock, so each rejection case has to be reached on purpose: writes and reads while busy, a wrong-row write after the lock, start attempts with enable or row mode missing, and standby accesses.

// File: rtl/nvr_pkg.sv
// Package: shared constants and types for the row-write controller.
// Assumes an 8-bit control register and byte-wide array cells.
package nvr_pkg;
    localparam int BYTE_W   = 8;
    localparam int CB_EN    = 0;
    localparam int CB_BUSY  = 1;
    localparam int CB_PMODE = 2;
    localparam int CB_START = 3;
    localparam int CB_STBY  = 6;

    typedef struct packed {
        logic stby;
        logic start;
        logic pmode;
        logic en;
    } ctl_t;

    // Builds the readable image of the control register; unused bits are 0.
    function automatic logic [BYTE_W-1:0] ctl_image(ctl_t c, logic bsy);
        logic [BYTE_W-1:0] v;
        v           = '0;
        v[CB_EN]    = c.en;
        v[CB_BUSY]  = bsy;
        v[CB_PMODE] = c.pmode;
        v[CB_START] = c.start;
        v[CB_STBY]  = c.stby;
        return v;
    endfunction
endpackage

// File: rtl/nvr_ctl_reg.sv
// Control register: holds enable, row mode, start and standby.
// Assumes writes arrive as single-cycle strobes. A start is accepted only
// when enable and row mode are already set and standby is clear. Hardware
// clears start and row mode at the end of a programming cycle.
module nvr_ctl_reg
    import nvr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctl,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              busy,
    input  logic              done,
    output ctl_t              ctl_q,
    output logic              start_go
);
    // Start is granted only when the register was already armed and the new
    // value keeps enable and row mode set and standby clear.
    always_comb begin
        start_go = wr_ctl && !busy
                 && ctl_q.en && ctl_q.pmode && !ctl_q.stby
                 && wdata[CB_START] && wdata[CB_PMODE]
                 && wdata[CB_EN] && !wdata[CB_STBY];
    end

    // Register update: the end of a cycle wins; control writes are ignored while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (done) begin
            ctl_q.start <= 1'b0;
            ctl_q.pmode <= 1'b0;
        end else if (wr_ctl && !busy) begin
            ctl_q.en    <= wdata[CB_EN];
            ctl_q.stby  <= wdata[CB_STBY];
            ctl_q.pmode <= wdata[CB_PMODE];
            ctl_q.start <= start_go;
        end
    end
endmodule

// File: rtl/nvr_row_latch.sv
// Row staging: eight volatile lanes with valid flags and a locked row address.
// Assumes cap is asserted only for accepted row-mode writes that hit the
// locked row (or any row while nothing is locked). clr empties everything.
module nvr_row_latch
    import nvr_pkg::*;
#(
    parameter  int ADDR_W    = 8,
    parameter  int ROW_BYTES = 8,
    localparam int OFF_W     = $clog2(ROW_BYTES),
    localparam int ROW_W     = ADDR_W - OFF_W
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                clr,
    input  logic                                cap,
    input  logic [ADDR_W-1:0]                   addr,
    input  logic [BYTE_W-1:0]                   wdata,
    output logic [ROW_W-1:0]                    row_q,
    output logic                                mism,
    output logic [ROW_BYTES-1:0][BYTE_W-1:0]    lane_data,
    output logic [ROW_BYTES-1:0]                lane_vld
);
    logic lock_q;

    // Flags an access to a row other than the locked one.
    always_comb mism = lock_q && (addr[ADDR_W-1:OFF_W] != row_q);

    // Row lock: taken on the first capture and released by clr.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
            row_q  <= '0;
        end else if (clr) begin
            lock_q <= 1'b0;
            row_q  <= '0;
        end else if (cap && !lock_q) begin
            lock_q <= 1'b1;
            row_q  <= addr[ADDR_W-1:OFF_W];
        end
    end

    // One lane per byte of the row.
    for (genvar g = 0; g < ROW_BYTES; g++) begin : g_lane
        logic hit;
        always_comb hit = cap && (addr[OFF_W-1:0] == OFF_W'(g));

        // Lane storage: a capture sets the valid flag and data; clr drops the flag.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lane_vld[g]  <= 1'b0;
                lane_data[g] <= '0;
            end else if (clr) begin
                lane_vld[g]  <= 1'b0;
            end else if (hit) begin
                lane_vld[g]  <= 1'b1;
                lane_data[g] <= wdata;
            end
        end
    end
endmodule

// File: rtl/nvr_prog_timer.sv
// Programming timer: a down-counter that sets the cycle length.
// Assumes load is asserted only while idle. busy is high for PROG_CYC
// cycles after load, and done marks the last one.
module nvr_prog_timer #(
    parameter  int PROG_CYC = 64,
    localparam int CNT_W    = $clog2(PROG_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy,
    output logic done
);
    logic [CNT_W-1:0] cnt_q;

    // Status decode from the counter.
    always_comb begin
        busy = (cnt_q != '0);
        done = (cnt_q == CNT_W'(1));
    end

    // Counter: loads the full length and counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= CNT_W'(PROG_CYC);
        end else if (busy) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/nvr_cell_array.sv
// Cell array: byte-addressed storage with a masked row write and a single-byte write.
// Assumes row_we and byte_we are never asserted together. Reads are combinational.
module nvr_cell_array
    import nvr_pkg::*;
#(
    parameter  int ADDR_W    = 8,
    parameter  int ROW_BYTES = 8,
    localparam int OFF_W     = $clog2(ROW_BYTES),
    localparam int ROW_W     = ADDR_W - OFF_W,
    localparam int DEPTH     = 1 << ADDR_W
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             row_we,
    input  logic [ROW_W-1:0]                 row_sel,
    input  logic [ROW_BYTES-1:0]             row_mask,
    input  logic [ROW_BYTES-1:0][BYTE_W-1:0] row_data,
    input  logic                             byte_we,
    input  logic [ADDR_W-1:0]                byte_addr,
    input  logic [BYTE_W-1:0]                byte_data,
    input  logic [ADDR_W-1:0]                rd_addr,
    output logic [BYTE_W-1:0]                rd_data
);
    logic [BYTE_W-1:0] mem [DEPTH];

    // Read port.
    always_comb rd_data = mem[rd_addr];

    // Write port: clears on reset, then applies the masked row or the single byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (row_we) begin
            for (int b = 0; b < ROW_BYTES; b++) begin
                if (row_mask[b]) mem[{row_sel, OFF_W'(b)}] <= row_data[b];
            end
        end else if (byte_we) begin
            mem[byte_addr] <= byte_data;
        end
    end
endmodule

// File: rtl/nvr_row_writer.sv
// Top: decodes the bus, gates array accesses, stages row writes and sequences programming.
// Assumes one access per cycle; if both strobes are set, the write wins.
// acc_err and bus_rdata are registered and appear the cycle after the access.
module nvr_row_writer
    import nvr_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int ROW_BYTES = 8,
    parameter int PROG_CYC  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_sel,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              rd_en,
    input  logic              wr_en,
    output logic              busy,
    output logic              acc_err
);
    localparam int OFF_W = $clog2(ROW_BYTES);
    localparam int ROW_W = ADDR_W - OFF_W;

    ctl_t                             ctl_q;
    logic                             start_go;
    logic                             done;
    logic                             ctl_wr, ctl_rd, dat_wr, dat_rd;
    logic                             byte_go, cap, mism, load;
    logic                             par_q;
    logic [ADDR_W-1:0]                baddr_q;
    logic [BYTE_W-1:0]                bdata_q;
    logic [ROW_W-1:0]                 row_q;
    logic [ROW_BYTES-1:0][BYTE_W-1:0] lane_data;
    logic [ROW_BYTES-1:0]             lane_vld;
    logic [BYTE_W-1:0]                arr_rd;

    // Bus decode, with the write taking priority.
    always_comb begin
        ctl_wr = wr_en && ctl_sel;
        ctl_rd = rd_en && !wr_en && ctl_sel;
        dat_wr = wr_en && !ctl_sel;
        dat_rd = rd_en && !wr_en && !ctl_sel;
    end

    // Admission of data writes to the byte path or to the row lanes.
    always_comb begin
        byte_go = dat_wr && !busy && !ctl_q.stby && !ctl_q.pmode && ctl_q.en;
        cap     = dat_wr && !busy && !ctl_q.stby && ctl_q.pmode && !mism;
        load    = start_go || byte_go;
    end

    nvr_ctl_reg u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctl   (ctl_wr),
        .wdata    (bus_wdata),
        .busy     (busy),
        .done     (done),
        .ctl_q    (ctl_q),
        .start_go (start_go)
    );

    nvr_row_latch #(.ADDR_W(ADDR_W), .ROW_BYTES(ROW_BYTES)) u_lat (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (!ctl_q.pmode),
        .cap       (cap),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .row_q     (row_q),
        .mism      (mism),
        .lane_data (lane_data),
        .lane_vld  (lane_vld)
    );

    nvr_prog_timer #(.PROG_CYC(PROG_CYC)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .busy  (busy),
        .done  (done)
    );

    nvr_cell_array #(.ADDR_W(ADDR_W), .ROW_BYTES(ROW_BYTES)) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .row_we    (done && par_q),
        .row_sel   (row_q),
        .row_mask  (lane_vld),
        .row_data  (lane_data),
        .byte_we   (done && !par_q),
        .byte_addr (baddr_q),
        .byte_data (bdata_q),
        .rd_addr   (bus_addr),
        .rd_data   (arr_rd)
    );

    // Pending job: records whether the cycle is a row or a byte, and the byte's target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_q   <= 1'b0;
            baddr_q <= '0;
            bdata_q <= '0;
        end else if (load) begin
            par_q <= start_go;
            if (byte_go) begin
                baddr_q <= bus_addr;
                bdata_q <= bus_wdata;
            end
        end
    end

    // Error flag: array access while busy, any row-mode read, or a wrong-row write.
    always_ff @(posedge clk) begin
        if (!rst_n) acc_err <= 1'b0;
        else        acc_err <= !ctl_q.stby && (dat_wr || dat_rd)
                               && (busy || (ctl_q.pmode && (dat_rd || mism)));
    end

    // Read data: control image, array byte, or zero for a refused read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (ctl_rd) begin
            bus_rdata <= ctl_image(ctl_q, busy);
        end else if (dat_rd) begin
            bus_rdata <= (!busy && !ctl_q.stby && !ctl_q.pmode) ? arr_rd : '0;
        end
    end
endmodule

// File: rtl/nvr_row_writer_chk.sv
// Checker: temporal properties of the row-write controller, bound to the top.
// Assumes single-cycle bus strobes and no standby together with a start.
module nvr_row_writer_chk #(
    parameter int PROG_CYC = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_sel,
    input logic       rd_en,
    input logic       wr_en,
    input logic [7:0] rd_data,
    input logic       busy,
    input logic       acc_err,
    input logic       en_q,
    input logic       pm_q,
    input logic       start_q,
    input logic       stby_q
);
    int unsigned bcnt;

    // Counts consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) bcnt <= 0;
        else        bcnt <= busy ? bcnt + 1 : 0;
    end

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && ctl_sel) |=> (rd_data[7] == 1'b0 && rd_data[5:4] == 2'b00));

    // R3
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (bcnt == PROG_CYC));

    // R6
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(start_q) |-> ($past(en_q) && $past(pm_q) && !$past(stby_q)));

    // R7
    done_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (!start_q && !pm_q));

    // R9
    busy_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ctl_sel && (rd_en || wr_en)) |=> acc_err);

    // R11
    stby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stby_q && !ctl_sel && (rd_en || wr_en)) |=> (!acc_err && !busy));
endmodule

bind nvr_row_writer nvr_row_writer_chk #(.PROG_CYC(PROG_CYC)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl_sel (ctl_sel),
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .rd_data (bus_rdata),
    .busy    (busy),
    .acc_err (acc_err),
    .en_q    (ctl_q.en),
    .pm_q    (ctl_q.pmode),
    .start_q (ctl_q.start),
    .stby_q  (ctl_q.stby)
);

// File: tb/nvr_row_writer_bench.sv
// Bench: directed scenarios plus a behavioural reference model compared on every clock.
module nvr_row_writer_bench;
    localparam int PROG = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_sel = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic       busy;
    logic       acc_err;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    nvr_row_writer #(.ADDR_W(8), .ROW_BYTES(8), .PROG_CYC(PROG)) u_nvr_row_writer (
        .clk(clk), .rst_n(rst_n), .ctl_sel(ctl_sel), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rd_en(rd_en),
        .wr_en(wr_en), .busy(busy), .acc_err(acc_err)
    );

    // ---------------- reference model ----------------
    logic [7:0] m_mem [256];
    logic [7:0] m_lat [8];
    logic [7:0] m_mask;
    int         m_cnt, m_row, m_baddr, row_in;
    logic       m_en, m_pm, m_start, m_stby, m_lock, m_par, m_err;
    logic [7:0] m_rd, m_bdata;
    logic       o_busy, o_en, o_pm, o_stby, o_start, cw, cr, dw, dr, mism, go;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
            m_mask = '0; m_cnt = 0; m_row = 0; m_lock = 0; m_par = 0;
            m_en = 0; m_pm = 0; m_start = 0; m_stby = 0; m_err = 0;
            m_rd = 8'h00; m_baddr = 0; m_bdata = 8'h00;
        end else begin
            o_busy = (m_cnt != 0); o_en = m_en; o_pm = m_pm;
            o_stby = m_stby; o_start = m_start;
            cw = wr_en && ctl_sel;  cr = rd_en && !wr_en && ctl_sel;
            dw = wr_en && !ctl_sel; dr = rd_en && !wr_en && !ctl_sel;
            row_in = int'(bus_addr) / 8;
            mism = m_lock && (row_in != m_row);
            if (cr) m_rd = {1'b0, o_stby, 2'b00, o_start, o_pm, o_busy, o_en};
            else if (dr) m_rd = (!o_busy && !o_stby && !o_pm) ? m_mem[bus_addr] : 8'h00;
            m_err = !o_stby && (dw || dr) && (o_busy || (o_pm && (dr || mism)));
            if (o_busy) begin
                if (m_cnt == 1) begin
                    if (m_par) begin
                        for (int i = 0; i < 8; i++)
                            if (m_mask[i]) m_mem[m_row * 8 + i] = m_lat[i];
                    end else begin
                        m_mem[m_baddr] = m_bdata;
                    end
                    m_start = 0; m_pm = 0;
                end
                m_cnt = m_cnt - 1;
            end
            if (cw && !o_busy) begin
                go = o_en && o_pm && !o_stby && bus_wdata[3] && bus_wdata[2]
                     && bus_wdata[0] && !bus_wdata[6];
                m_en = bus_wdata[0]; m_stby = bus_wdata[6];
                m_pm = bus_wdata[2]; m_start = go;
                if (go) begin m_cnt = PROG; m_par = 1; end
            end
            if (dw && !o_busy && !o_stby) begin
                if (o_pm) begin
                    if (!mism) begin
                        if (!m_lock) begin m_lock = 1; m_row = row_in; end
                        m_lat[bus_addr % 8]  = bus_wdata;
                        m_mask[bus_addr % 8] = 1'b1;
                    end
                end else if (o_en) begin
                    m_cnt = PROG; m_par = 0; m_baddr = int'(bus_addr); m_bdata = bus_wdata;
                end
            end
            if (!o_pm) begin m_mask = '0; m_lock = 0; end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3 model busy", 32'(busy), 32'(m_cnt != 0));
            chk("R9 model acc_err", 32'(acc_err), 32'(m_err));
            chk("R2 model rdata", 32'(bus_rdata), 32'(m_rd));
        end
    end

    // ---------------- bus tasks (called at a falling edge) ----------------
    logic [7:0] rv;
    logic       ev;
    int         nb;

    task automatic bwr(input logic c, input logic [7:0] a, input logic [7:0] d);
        ctl_sel = c; bus_addr = a; bus_wdata = d; wr_en = 1'b1;
        @(negedge clk);
        ev = acc_err;
        wr_en = 1'b0; ctl_sel = 1'b0;
    endtask

    task automatic brd(input logic c, input logic [7:0] a);
        ctl_sel = c; bus_addr = a; rd_en = 1'b1;
        @(negedge clk);
        rv = bus_rdata; ev = acc_err;
        rd_en = 1'b0; ctl_sel = 1'b0;
    endtask

    task automatic wait_idle();
        nb = 0;
        while (busy) begin nb++; @(negedge clk); end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 busy after reset", 32'(busy), 0);
        chk("R1 acc_err after reset", 32'(acc_err), 0);
        chk("R1 rdata after reset", 32'(bus_rdata), 0);
        brd(1, 0);    chk("R1 ctl reset", 32'(rv), 32'h00);
        brd(0, 8'h05); chk("R1 array reset", 32'(rv), 32'h00);

        // R2 / R6: all bits written while unarmed
        bwr(1, 0, 8'hFF); brd(1, 0);
        chk("R2 ctl image", 32'(rv), 32'h45);
        chk("R6 no start unarmed", 32'(busy), 0);
        bwr(1, 0, 8'h00);

        // R3 byte mode
        bwr(1, 0, 8'h01);
        bwr(0, 8'h21, 8'hA5);
        chk("R3 busy after write", 32'(busy), 1);
        wait_idle();
        chk("R3 busy length", nb, PROG);
        brd(0, 8'h21); chk("R3 byte stored", 32'(rv), 32'hA5);

        // R9 during busy
        bwr(0, 8'h22, 8'h11);
        bwr(0, 8'h21, 8'h00); chk("R9 write while busy err", 32'(ev), 1);
        brd(0, 8'h21);        chk("R9 read while busy err", 32'(ev), 1);
        chk("R9 read while busy data", 32'(rv), 0);
        bwr(1, 0, 8'h00); brd(1, 0);
        chk("R9 ctl write ignored", 32'(rv), 32'h03);
        wait_idle();
        brd(0, 8'h21); chk("R9 rejected write no effect", 32'(rv), 32'hA5);
        brd(0, 8'h22); chk("R9 cycle completes", 32'(rv), 32'h11);

        // R12 disabled
        bwr(1, 0, 8'h00);
        bwr(0, 8'h30, 8'h77);
        chk("R12 no cycle", 32'(busy), 0);
        chk("R12 no error", 32'(ev), 0);
        brd(0, 8'h30); chk("R12 array unchanged", 32'(rv), 0);

        // prefill neighbours
        bwr(1, 0, 8'h01);
        bwr(0, 8'h19, 8'h99); wait_idle();
        bwr(0, 8'h1C, 8'hCC); wait_idle();

        // R4 / R5 / R10 row commit
        bwr(1, 0, 8'h05); brd(1, 0); chk("R4 row mode set", 32'(rv), 32'h05);
        bwr(0, 8'h18, 8'h18); chk("R4 first write locks", 32'(ev), 0);
        bwr(0, 8'h1A, 8'h1A);
        bwr(0, 8'h1B, 8'h1B);
        bwr(0, 8'h20, 8'h20); chk("R10 wrong row err", 32'(ev), 1);
        brd(0, 8'h18); chk("R10 row-mode read err", 32'(ev), 1);
        chk("R10 row-mode read data", 32'(rv), 0);
        bwr(1, 0, 8'h0D); brd(1, 0);
        chk("R6 start accepted", 32'(rv), 32'h0F);
        wait_idle();
        brd(1, 0); chk("R7 start and mode cleared", 32'(rv), 32'h01);
        brd(0, 8'h18); chk("R5 byte 18", 32'(rv), 32'h18);
        brd(0, 8'h19); chk("R5 byte 19 kept", 32'(rv), 32'h99);
        brd(0, 8'h1A); chk("R5 byte 1A", 32'(rv), 32'h1A);
        brd(0, 8'h1B); chk("R5 byte 1B", 32'(rv), 32'h1B);
        brd(0, 8'h1C); chk("R5 byte 1C kept", 32'(rv), 32'hCC);
        brd(0, 8'h1D); chk("R5 byte 1D kept", 32'(rv), 32'h00);
        brd(0, 8'h20); chk("R10 other row not captured", 32'(rv), 32'h00);

        // R6 refused starts
        bwr(1, 0, 8'h0D); brd(1, 0);
        chk("R6 start without mode", 32'(rv), 32'h05);
        bwr(1, 0, 8'h04);
        bwr(1, 0, 8'h0D); brd(1, 0);
        chk("R6 start without enable", 32'(rv), 32'h05);
        chk("R6 no cycle", 32'(busy), 0);

        // R8 discard
        bwr(0, 8'h40, 8'h44);
        bwr(1, 0, 8'h01);
        bwr(1, 0, 8'h05);
        bwr(1, 0, 8'h0D);
        wait_idle();
        brd(0, 8'h40); chk("R8 discarded lane", 32'(rv), 32'h00);
        brd(0, 8'h18); chk("R8 row untouched", 32'(rv), 32'h18);

        // R11 standby
        bwr(1, 0, 8'h41);
        bwr(0, 8'h50, 8'h55);
        chk("R11 no cycle", 32'(busy), 0);
        chk("R11 no err on write", 32'(ev), 0);
        brd(0, 8'h21); chk("R11 read zero", 32'(rv), 32'h00);
        chk("R11 no err on read", 32'(ev), 0);
        bwr(1, 0, 8'h01);
        brd(0, 8'h50); chk("R11 write had no effect", 32'(rv), 32'h00);
        brd(0, 8'h21); chk("R11 data kept", 32'(rv), 32'hA5);

        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule